// File: doc/BRIEF.md
# Host Data Register Byte Port

This block sits between an 8-bit host bus and a 16-bit data register that a coprocessor core exchanges with the host. A mode input sets the width of each transfer. In 16-bit mode a word moves as two byte accesses, most significant byte first. A byte-sequence status bit records which half comes next. In 8-bit mode a single byte access covers the whole transfer.

A request status bit tells the host that the core has data ready or is waiting for data. The core sets the request bit when it writes the register through its own full-width port. The host access that completes a transfer clears it. The core sees the register contents at all times on a full-width output.

The register width is a parameter: a number of byte lanes times the byte width. In wide mode the sequence walks from the top lane down to lane 0. The default is two lanes of 8 bits.

Top module: `hdr_byte_port`

## Requirements
- R1: After reset the data register is 0, the request bit (`ready_o`) is 0 and the byte sequence (`seq_o`) is 0.
- R2: A core write (`core_wr_i`=1) loads the whole register from `core_wdata_i`, sets `ready_o` to 1 and returns `seq_o` to 0, all at the next clock edge. `core_rdata_o` always shows the current register.
- R3: In wide mode (`wide_i`=1) with `seq_o`=0, `host_rdata_o` shows register bits [15:8] during the read strobe. At the edge, `seq_o` becomes 1 and `ready_o` keeps its value.
- R4: In wide mode with `seq_o`=1, `host_rdata_o` shows bits [7:0] during the read strobe. At the edge, `seq_o` returns to 0 and `ready_o` clears.
- R5: A wide-mode host write with `seq_o`=0 puts `host_wdata_i` into bits [15:8] and keeps bits [7:0]. `seq_o` becomes 1 and `ready_o` is unchanged.
- R6: A wide-mode host write with `seq_o`=1 puts `host_wdata_i` into bits [7:0] and keeps bits [15:8]. `seq_o` returns to 0 and `ready_o` clears.
- R7: In narrow mode (`wide_i`=0) a host read shows bits [7:0] on `host_rdata_o` and clears `ready_o`. The register and `seq_o` are unchanged.
- R8: In narrow mode a host write sets the whole register to `host_wdata_i` zero-extended and clears `ready_o`. `seq_o` is unchanged.
- R9: When the core writes in the same cycle as a host read or write, the core write takes effect and the host access does nothing: the register holds the core word, `ready_o` is 1 and `seq_o` is 0.
- R10: When `host_rd_i` and `host_wr_i` are both high and there is no core write, only the write is performed and the sequence advances by a single step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_i | input | 1 | Transfer mode: 1 = 16-bit (two byte accesses), 0 = 8-bit |
| host_rd_i | input | 1 | Host read strobe, one byte per cycle |
| host_wr_i | input | 1 | Host write strobe, one byte per cycle |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Byte the host read returns (combinational) |
| core_wr_i | input | 1 | Core full-width write strobe |
| core_wdata_i | input | 16 | Core write word |
| core_rdata_o | output | 16 | Current register contents for the core |
| ready_o | output | 1 | Request bit: a transfer is pending for the host |
| seq_o | output | 1 | Byte sequence: next wide access targets the low byte when 1 |

## Verification
The hardest state to reach from the ports is a half-finished wide transfer: `seq_o` at 1 with `ready_o` still set. A second event then has to land in that state, for example a core write, a narrow access or a read that coincides with a write. The stimulus stops a wide read or write after its first byte and then applies each of these disturbances. It also runs wide transfers back to back, with no idle cycle between the second byte of one word and the first byte of the next. A reference model, written from the requirements, tracks the register, the request bit and the sequence. The register, `ready_o` and `seq_o` are compared against this model after every cycle.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_CORE,
    ACC_WIDE_RD,
    ACC_WIDE_WR,
    ACC_NARR_RD,
    ACC_NARR_WR
  } acc_e;

  // core beats host; host write beats host read
  function automatic acc_e classify(input logic core_wr, input logic host_rd,
                                    input logic host_wr, input logic wide);
    if (core_wr)      return ACC_CORE;
    else if (host_wr) return wide ? ACC_WIDE_WR : ACC_NARR_WR;
    else if (host_rd) return wide ? ACC_WIDE_RD : ACC_NARR_RD;
    else              return ACC_IDLE;
  endfunction

endpackage

// File: rtl/hdr_seq_ctrl.sv
module hdr_seq_ctrl
  import hdr_pkg::*;
#(
  parameter int LANES = 2,
  localparam int SEQ_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_e             acc_i,
  output logic [SEQ_W-1:0] seq_o,
  output logic             req_o,
  output logic             last_o,
  output logic [LANES-1:0] lane_sel_o
);

  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(LANES - 1);

  logic [SEQ_W-1:0] seq_q;
  logic             req_q;
  logic             wide_acc;

  assign wide_acc = (acc_i == ACC_WIDE_RD) || (acc_i == ACC_WIDE_WR);
  assign last_o   = (seq_q == SEQ_LAST);

  // most significant lane is visited first
  for (genvar i = 0; i < LANES; i++) begin : g_sel
    assign lane_sel_o[i] = (seq_q == SEQ_W'(LANES - 1 - i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= '0;
      req_q <= 1'b0;
    end else begin
      unique case (acc_i)
        ACC_CORE: begin
          seq_q <= '0;
          req_q <= 1'b1;
        end
        ACC_WIDE_RD, ACC_WIDE_WR: begin
          if (last_o) begin
            seq_q <= '0;
            req_q <= 1'b0;
          end else begin
            seq_q <= seq_q + 1'b1;
          end
        end
        ACC_NARR_RD, ACC_NARR_WR: req_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign seq_o = seq_q;
  assign req_o = req_q;

  // R2
  req_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> ($past(acc_i) == ACC_CORE));

  // R4
  wide_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_acc && last_o) |=> (!req_q && seq_q == '0));

  // R3
  wide_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_acc && !last_o) |=> (seq_q == $past(seq_q) + 1'b1 && req_q == $past(req_q)));

  // R8
  narrow_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_NARR_WR || acc_i == ACC_NARR_RD) |=> ($stable(seq_q) && !req_q));

endmodule

// File: rtl/hdr_lane_reg.sv
module hdr_lane_reg
  import hdr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [LANES-1:0]  lane_sel_i,
  input  logic [BYTE_W-1:0] host_byte_i,
  input  logic [WORD_W-1:0] core_word_i,
  output logic [WORD_W-1:0] word_o
);

  logic [BYTE_W-1:0] lane_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q[i] <= '0;
      end else begin
        unique case (acc_i)
          ACC_CORE:    lane_q[i] <= core_word_i[i*BYTE_W +: BYTE_W];
          ACC_WIDE_WR: if (lane_sel_i[i]) lane_q[i] <= host_byte_i;
          ACC_NARR_WR: lane_q[i] <= (i == 0) ? host_byte_i : '0;
          default: ;
        endcase
      end
    end

    assign word_o[i*BYTE_W +: BYTE_W] = lane_q[i];

    // R5
    lane_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_i == ACC_WIDE_WR && !lane_sel_i[i]) |=> $stable(lane_q[i]));
  end

  // R8
  narrow_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_NARR_WR) |=> (word_o == WORD_W'($past(host_byte_i))));

  // R2
  core_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_CORE) |=> (word_o == $past(core_word_i)));

  // R7
  read_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_NARR_RD || acc_i == ACC_WIDE_RD) |=> $stable(word_o));

endmodule

// File: rtl/hdr_byte_port.sv
module hdr_byte_port
  import hdr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int SEQ_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic              core_wr_i,
  input  logic [WORD_W-1:0] core_wdata_i,
  output logic [WORD_W-1:0] core_rdata_o,
  output logic              ready_o,
  output logic [SEQ_W-1:0]  seq_o
);

  acc_e             acc;
  logic [LANES-1:0] lane_sel;
  logic             last;
  logic [WORD_W-1:0] word;

  assign acc = classify(core_wr_i, host_rd_i, host_wr_i, wide_i);

  hdr_seq_ctrl #(.LANES(LANES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .seq_o      (seq_o),
    .req_o      (ready_o),
    .last_o     (last),
    .lane_sel_o (lane_sel)
  );

  hdr_lane_reg #(.BYTE_W(BYTE_W), .LANES(LANES)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .lane_sel_i  (lane_sel),
    .host_byte_i (host_wdata_i),
    .core_word_i (core_wdata_i),
    .word_o      (word)
  );

  // narrow mode always reads lane 0; wide mode reads the sequenced lane
  always_comb begin
    host_rdata_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (wide_i ? lane_sel[i] : (i == 0))
        host_rdata_o = host_rdata_o | word[i*BYTE_W +: BYTE_W];
    end
  end

  assign core_rdata_o = word;

  // R9
  core_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_i |=> (ready_o && seq_o == '0 && core_rdata_o == $past(core_wdata_i)));

  // R10
  wr_over_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_wr_i && host_wr_i && host_rd_i && wide_i && !last) |=>
      (seq_o == $past(seq_o) + 1'b1));

  // R4
  wide_last_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_wr_i && !host_wr_i && host_rd_i && wide_i && last) |->
      (host_rdata_o == core_rdata_o[BYTE_W-1:0]));

endmodule

// File: tb/hdr_byte_port_tb.sv
module hdr_byte_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b0;
  logic        host_rd_i = 1'b0;
  logic        host_wr_i = 1'b0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;
  logic        core_wr_i = 1'b0;
  logic [15:0] core_wdata_i = '0;
  logic [15:0] core_rdata_o;
  logic        ready_o;
  logic [0:0]  seq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_byte_port u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wide_i       (wide_i),
    .host_rd_i    (host_rd_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .core_wr_i    (core_wr_i),
    .core_wdata_i (core_wdata_i),
    .core_rdata_o (core_rdata_o),
    .ready_o      (ready_o),
    .seq_o        (seq_o)
  );

  localparam int SEL_RDATA = 0;
  localparam int SEL_WORD  = 1;
  localparam int SEL_REQ   = 2;
  localparam int SEL_SEQ   = 3;

  typedef struct {
    string       tag;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state from the requirements
  logic [15:0] m_dr  = '0;
  logic        m_req = 1'b0;
  logic        m_seq = 1'b0;
  string       last_tag = "R1 reset";

  task automatic push(input string tag, input int sel, input logic [15:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  // monitor: compares everything queued for this cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.sel)
          SEL_RDATA: act = {8'h00, host_rdata_o};
          SEL_WORD:  act = core_rdata_o;
          SEL_REQ:   act = {15'h0, ready_o};
          default:   act = {15'h0, seq_o};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  // driver: checks state left by the previous cycle, drives, predicts
  task automatic step(input string tag, input logic cw, input logic [15:0] cd,
                      input logic hr, input logic hw, input logic [7:0] hd,
                      input logic wide);
    @(negedge clk);
    push(last_tag, SEL_WORD, m_dr);
    push(last_tag, SEL_REQ, {15'h0, m_req});
    push(last_tag, SEL_SEQ, {15'h0, m_seq});
    core_wr_i = cw; core_wdata_i = cd;
    host_rd_i = hr; host_wr_i = hw; host_wdata_i = hd; wide_i = wide;
    if (hr && !hw && !cw)
      push(tag, SEL_RDATA, {8'h00, wide ? (m_seq ? m_dr[7:0] : m_dr[15:8]) : m_dr[7:0]});
    if (cw) begin
      m_dr = cd; m_req = 1'b1; m_seq = 1'b0;
    end else if (hw) begin
      if (wide) begin
        if (!m_seq) begin m_dr[15:8] = hd; m_seq = 1'b1; end
        else begin m_dr[7:0] = hd; m_seq = 1'b0; m_req = 1'b0; end
      end else begin
        m_dr = {8'h00, hd}; m_req = 1'b0;
      end
    end else if (hr) begin
      if (wide) begin
        if (!m_seq) m_seq = 1'b1;
        else begin m_seq = 1'b0; m_req = 1'b0; end
      end else m_req = 1'b0;
    end
    last_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 16'h0, 1'b0, 1'b0, 8'h00, wide_i);
  endtask

  task automatic core_wr(input string tag, input logic [15:0] d);
    step(tag, 1'b1, d, 1'b0, 1'b0, 8'h00, wide_i);
  endtask

  task automatic host_rd(input string tag, input logic wide);
    step(tag, 1'b0, 16'h0, 1'b1, 1'b0, 8'h00, wide);
  endtask

  task automatic host_wr(input string tag, input logic wide, input logic [7:0] d);
    step(tag, 1'b0, 16'h0, 1'b0, 1'b1, d, wide);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset values
    idle("R1 reset");
    // R2 core load and wide reads: R3 high byte then R4 low byte
    core_wr("R2 core load", 16'hA55C);
    host_rd("R3 wide rd hi", 1'b1);
    host_rd("R4 wide rd lo", 1'b1);
    idle("R4 after");
    // back-to-back wide reads of two words
    core_wr("R2 load 2", 16'h1234);
    host_rd("R3 b2b hi", 1'b1);
    host_rd("R4 b2b lo", 1'b1);
    host_rd("R3 b2b hi2", 1'b1);
    host_rd("R4 b2b lo2", 1'b1);
    // R5 R6 wide writes, back to back
    core_wr("R2 arm", 16'h0F0F);
    host_wr("R5 wide wr hi", 1'b1, 8'hC3);
    host_wr("R6 wide wr lo", 1'b1, 8'h7E);
    host_wr("R5 b2b hi", 1'b1, 8'h11);
    host_wr("R6 b2b lo", 1'b1, 8'h22);
    idle("R6 after");
    // R7 narrow read
    core_wr("R2 arm narrow", 16'hBEEF);
    host_rd("R7 narrow rd", 1'b0);
    idle("R7 after");
    // R8 narrow write zero-extends
    core_wr("R2 arm nw", 16'hFFFF);
    host_wr("R8 narrow wr", 1'b0, 8'h5A);
    idle("R8 after");
    // narrow access in the middle of a wide transfer keeps the sequence
    core_wr("R2 arm mid", 16'h8001);
    host_rd("R3 mid hi", 1'b1);
    host_rd("R7 narrow mid", 1'b0);
    host_rd("R4 after narrow", 1'b1);
    core_wr("R2 arm mid w", 16'h4321);
    host_wr("R5 mid hi", 1'b1, 8'h99);
    host_wr("R8 narrow mid", 1'b0, 8'h66);
    host_wr("R6 after narrow", 1'b1, 8'h77);
    idle("R8 seq kept");
    // R9 core write beats host access, including mid-transfer
    core_wr("R2 arm r9", 16'h0102);
    host_rd("R3 r9 hi", 1'b1);
    step("R9 core vs host rd", 1'b1, 16'hCAFE, 1'b1, 1'b0, 8'h00, 1'b1);
    host_wr("R5 r9 hi", 1'b1, 8'hAB);
    step("R9 core vs host wr", 1'b1, 16'hD00D, 1'b0, 1'b1, 8'hEE, 1'b1);
    step("R9 core vs narrow wr", 1'b1, 16'h3C3C, 1'b0, 1'b1, 8'h01, 1'b0);
    idle("R9 after");
    // R10 simultaneous read and write: write only, single step
    step("R10 rd+wr hi", 1'b0, 16'h0, 1'b1, 1'b1, 8'h5E, 1'b1);
    step("R10 rd+wr lo", 1'b0, 16'h0, 1'b1, 1'b1, 8'hA1, 1'b1);
    idle("R10 after");
    core_wr("R2 final", 16'h00FF);
    host_rd("R3 final hi", 1'b1);
    host_rd("R4 final lo", 1'b1);
    idle("R4 final after");
    idle("R4 final idle");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule